// File: doc/BRIEF.md
# Prioritized ADC Trigger Arbiter

The block collects conversion requests from ten trigger sources and passes them one at a time to a downstream conversion sequencer. Sources 0 to 7 are general-purpose crossbar triggers. Sources 8 and 9 are touch-controller triggers. Each request is held as pending until it wins arbitration. The winner is the pending source with the highest programmed 3-bit priority.

Each crossbar source takes its request from one of two places. In hardware mode it uses its crossbar input. In software mode it uses a self-clearing software trigger bit. An enable mask gates the crossbar sources. The touch sources take hardware requests only. A bypass control removes the touch sources from arbitration, and a per-source touch enable applies while bypass is off. A soft reset clears all pending state.

The sequencer raises `seq_ready` when it can accept work. While it is high, the block issues at most one grant per cycle as a one-cycle `grant_valid` pulse with the source index.

Top module: `trig_arbiter`

## Requirements
- R1: After reset, and with the default configuration, `grant_valid` is 0. The default configuration is bypass on, both touch enables off, crossbar mask zero and all priorities zero. With that configuration, pulses on every trigger input produce no grant.
- R2: Crossbar source n is accepted only when bit n of `xbar_en` is 1 (0x01 enables source 0, 0x80 enables source 7). A request from a disabled crossbar source is ignored and never granted.
- R3: The priority of source n is `prio_i[3n+2:3n]`. Among pending sources, the one with the larger priority value is granted first, where 7 is the highest and 0 the lowest.
- R4: When pending sources have equal priority, the lower source index is granted first.
- R5: A request is held pending until it is granted. A grant is issued only in a cycle where `seq_ready` was 1 at the preceding clock edge. Each accepted request produces exactly one grant.
- R6: When `xbar_sw_mode[n]` is 1, a one-cycle pulse on `sw_trig_wr[n]` sets a software trigger bit on the next edge. That bit produces a single request and clears itself one cycle later. In this mode the hardware input of source n is ignored. When `xbar_sw_mode[n]` is 0, the software bit is ignored.
- R7: The touch sources (index 8 from `touch_trig_i[0]`, index 9 from `touch_trig_i[1]`) take hardware requests only. While `touch_bypass` is 1 their requests are ignored. While bypass is 0, touch source j is accepted only if `touch_en[j]` is 1.
- R8: `soft_rst` held for one cycle clears all pending requests, software trigger bits and the grant output, so no grant follows for requests made before it.
- R9: With a request pending and `seq_ready` raised, `grant_valid` is 1 in the cycle after the edge that samples `seq_ready`. It lasts one cycle per grant, and `grant_idx` carries the source index 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous clear of all arbiter state |
| xbar_trig_i | input | 8 | Crossbar hardware trigger pulses, bit n for source n |
| xbar_en | input | 8 | Crossbar source enable mask |
| xbar_sw_mode | input | 8 | 1 selects software triggering for crossbar source n |
| sw_trig_wr | input | 8 | Software trigger write strobes, bit n for source n |
| touch_trig_i | input | 2 | Touch hardware trigger pulses (sources 8, 9) |
| touch_en | input | 2 | Touch source enables, used while bypass is off |
| touch_bypass | input | 1 | 1 removes the touch sources from arbitration |
| prio_i | input | 30 | Priorities, 3 bits per source, source n at bits 3n+2:3n |
| seq_ready | input | 1 | Sequencer can accept a grant |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_idx | output | 4 | Index of the granted source |

## Verification
A hardware pulse becomes pending at the edge that samples it. A software write needs one extra edge, because it passes through the self-clearing bit first. A grant appears one edge after `seq_ready` is sampled high, and the bench checks `grant_valid` at the first falling edge after that rising edge. All stimulus is applied while `seq_ready` is low, and the bench computes the expected grant order from the programmed priorities and index order. The monitor then takes one expected index for each grant pulse. Any grant that arrives when none is expected, or in a cycle whose preceding edge saw `seq_ready` low, is reported as a failure. After each drain window the bench confirms that no expected grant is still outstanding.

// File: rtl/trig_arb_pkg.sv
package trig_arb_pkg;

    localparam int DEF_N_XBAR  = 8;
    localparam int DEF_N_TOUCH = 2;
    localparam int DEF_PRIO_W  = 3;

    // Candidate beats the current best only when strictly higher,
    // so a scan in ascending index order keeps the lower index on ties.
    function automatic logic prio_beats(input logic [7:0] cand, input logic [7:0] best,
                                        input logic have_best);
        return !have_best || (cand > best);
    endfunction

endpackage

// File: rtl/trig_req_front.sv
module trig_req_front #(
    parameter int N_XBAR  = 8,
    parameter int N_TOUCH = 2,
    localparam int N_SRC  = N_XBAR + N_TOUCH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  logic [N_XBAR-1:0]  xbar_hw,
    input  logic [N_XBAR-1:0]  xbar_en,
    input  logic [N_XBAR-1:0]  sw_mode,
    input  logic [N_XBAR-1:0]  sw_wr,
    input  logic [N_TOUCH-1:0] touch_hw,
    input  logic [N_TOUCH-1:0] touch_en,
    input  logic               touch_bypass,
    output logic [N_SRC-1:0]   req
);

    logic [N_XBAR-1:0] sw_bits;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) sw_bits <= '0;
        else                 sw_bits <= sw_wr;
    end

    for (genvar i = 0; i < N_XBAR; i++) begin : g_xbar
        assign req[i] = xbar_en[i] & (sw_mode[i] ? sw_bits[i] : xbar_hw[i]);
    end

    for (genvar j = 0; j < N_TOUCH; j++) begin : g_touch
        assign req[N_XBAR+j] = !touch_bypass & touch_en[j] & touch_hw[j];
    end

    // R6
    sw_self_clear_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
        ((sw_bits != '0) && (sw_wr == '0)) |=> (sw_bits == '0));

    // R7
    touch_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        touch_bypass |-> (req[N_SRC-1:N_XBAR] == '0));

endmodule

// File: rtl/trig_pend.sv
module trig_pend #(
    parameter int N_SRC = 10,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic [N_SRC-1:0] req,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [N_SRC-1:0] pend
);

    logic [N_SRC-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        for (int k = 0; k < N_SRC; k++)
            if (clr_en && (clr_idx == IDX_W'(k))) clr_mask[k] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) pend <= '0;
        else                 pend <= (pend & ~clr_mask) | req;
    end

    // R8
    soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (pend == '0));

    // R5
    req_latched_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (req != '0) |=> ((pend & $past(req)) == $past(req)));

    // R5
    grant_retires_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (clr_en && !req[clr_idx]) |=> !pend[$past(clr_idx)]);

endmodule

// File: rtl/trig_pick.sv
module trig_pick
    import trig_arb_pkg::*;
#(
    parameter int N_SRC  = 10,
    parameter int PRIO_W = 3,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]        pend,
    input  logic [N_SRC*PRIO_W-1:0] prio,
    output logic                    any,
    output logic [IDX_W-1:0]        win
);

    logic [7:0] best;

    always_comb begin
        any  = 1'b0;
        win  = '0;
        best = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (pend[k] && prio_beats(8'(prio[k*PRIO_W +: PRIO_W]), best, any)) begin
                any  = 1'b1;
                win  = IDX_W'(k);
                best = 8'(prio[k*PRIO_W +: PRIO_W]);
            end
        end
    end

endmodule

// File: rtl/trig_arbiter.sv
module trig_arbiter
    import trig_arb_pkg::*;
#(
    parameter int N_XBAR  = DEF_N_XBAR,
    parameter int N_TOUCH = DEF_N_TOUCH,
    parameter int PRIO_W  = DEF_PRIO_W,
    localparam int N_SRC  = N_XBAR + N_TOUCH,
    localparam int IDX_W  = $clog2(N_SRC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    soft_rst,
    input  logic [N_XBAR-1:0]       xbar_trig_i,
    input  logic [N_XBAR-1:0]       xbar_en,
    input  logic [N_XBAR-1:0]       xbar_sw_mode,
    input  logic [N_XBAR-1:0]       sw_trig_wr,
    input  logic [N_TOUCH-1:0]      touch_trig_i,
    input  logic [N_TOUCH-1:0]      touch_en,
    input  logic                    touch_bypass,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    input  logic                    seq_ready,
    output logic                    grant_valid,
    output logic [IDX_W-1:0]        grant_idx
);

    logic [N_SRC-1:0] req;
    logic [N_SRC-1:0] pend;
    logic             any;
    logic [IDX_W-1:0] win;
    logic             fire;

    assign fire = seq_ready && any;

    trig_req_front #(.N_XBAR(N_XBAR), .N_TOUCH(N_TOUCH)) u_front (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .xbar_hw(xbar_trig_i), .xbar_en(xbar_en), .sw_mode(xbar_sw_mode),
        .sw_wr(sw_trig_wr), .touch_hw(touch_trig_i), .touch_en(touch_en),
        .touch_bypass(touch_bypass), .req(req)
    );

    trig_pend #(.N_SRC(N_SRC)) u_pend (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .req(req),
        .clr_en(fire), .clr_idx(win), .pend(pend)
    );

    trig_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_pick (
        .pend(pend), .prio(prio_i), .any(any), .win(win)
    );

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            grant_valid <= 1'b0;
            grant_idx   <= '0;
        end else begin
            grant_valid <= fire;
            if (fire) grant_idx <= win;
        end
    end

    // R5
    grant_needs_ready_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
        grant_valid |-> $past(seq_ready));

    // R3
    winner_pending_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> pend[win]);

    // R9
    grant_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (grant_idx < IDX_W'(N_SRC)));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> !grant_valid);

endmodule

// File: tb/sim_trig_arbiter.sv
module sim_trig_arbiter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst = 1'b0;
    logic [7:0] xbar_trig_i = '0;
    logic [7:0] xbar_en = '0;
    logic [7:0] xbar_sw_mode = '0;
    logic [7:0] sw_trig_wr = '0;
    logic [1:0] touch_trig_i = '0;
    logic [1:0] touch_en = '0;
    logic       touch_bypass = 1'b1;
    logic [29:0] prio_i = '0;
    logic       seq_ready = 1'b0;
    logic       grant_valid;
    logic [3:0] grant_idx;

    always #10 clk = ~clk;

    trig_arbiter u0 (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .xbar_trig_i(xbar_trig_i),
        .xbar_en(xbar_en), .xbar_sw_mode(xbar_sw_mode), .sw_trig_wr(sw_trig_wr),
        .touch_trig_i(touch_trig_i), .touch_en(touch_en), .touch_bypass(touch_bypass),
        .prio_i(prio_i), .seq_ready(seq_ready), .grant_valid(grant_valid),
        .grant_idx(grant_idx)
    );

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int p[10];
    logic rdy_at_edge = 1'b0;
    logic mon_on = 1'b0;
    int cycles = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_prio();
        for (int i = 0; i < 10; i++) prio_i[i*3 +: 3] = 3'(p[i]);
    endtask

    // Reference order: highest value first, lower index on ties (R3, R4)
    task automatic expect_set(input logic [9:0] set);
        logic [9:0] s;
        s = set;
        while (s != '0) begin
            int best;
            best = -1;
            for (int i = 0; i < 10; i++)
                if (s[i] && (best < 0 || p[i] > p[best])) best = i;
            exp_q.push_back(best);
            s[best] = 1'b0;
        end
    endtask

    task automatic pulse(input logic [7:0] hw, input logic [1:0] th, input logic [7:0] sw);
        @(negedge clk);
        xbar_trig_i = hw; touch_trig_i = th; sw_trig_wr = sw;
        @(negedge clk);
        xbar_trig_i = '0; touch_trig_i = '0; sw_trig_wr = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic drain(input bit chk_first, input string tag);
        @(negedge clk);
        seq_ready = 1'b1;
        @(negedge clk);
        if (chk_first) chk(grant_valid == 1'b1, "R9", int'(grant_valid), 1);
        repeat (14) @(negedge clk);
        seq_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    always @(posedge clk) begin
        rdy_at_edge <= seq_ready;
        cycles <= cycles + 1;
    end

    // Monitor: one expected index per grant pulse
    always @(negedge clk) begin
        if (mon_on && grant_valid) begin
            if (!rdy_at_edge) chk(1'b0, "R5 grant without ready", 1, 0);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2/R5/R6/R7/R8 unexpected grant", int'(grant_idx), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(grant_idx) == e, "R3/R4 grant order", int'(grant_idx), e);
            end
        end
    end

    initial begin
        for (int i = 0; i < 10; i++) p[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(grant_valid == 1'b0, "R1 reset valid", int'(grant_valid), 0);
        chk(grant_idx == 4'd0, "R1 reset idx", int'(grant_idx), 0);
        mon_on = 1'b1;

        // R1 defaults: everything ignored
        pulse(8'hFF, 2'b11, 8'hFF);
        drain(1'b0, "R1 defaults");

        // R3 distinct priorities, hardware mode, all enabled
        p[0]=2; p[1]=5; p[2]=7; p[3]=0; p[4]=5; p[5]=1; p[6]=7; p[7]=3;
        set_prio();
        xbar_en = 8'hFF;
        pulse(8'hFF, 2'b00, 8'h00);
        expect_set(10'h0FF);
        drain(1'b1, "R3 all grants");

        // R4 equal priorities
        for (int i = 0; i < 10; i++) p[i] = 4;
        set_prio();
        pulse(8'b1010_0110, 2'b00, 8'h00);
        expect_set(10'b00_1010_0110);
        drain(1'b1, "R4 all grants");

        // R2 mask 0x05
        xbar_en = 8'h05;
        pulse(8'hFF, 2'b00, 8'h00);
        expect_set(10'h005);
        drain(1'b0, "R2 mask");

        // R6 software mode on source 3: hardware ignored, write grants once
        xbar_en = 8'hFF;
        xbar_sw_mode = 8'h08;
        pulse(8'h08, 2'b00, 8'h00);
        drain(1'b0, "R6 hw ignored");
        pulse(8'h00, 2'b00, 8'h08);
        expect_set(10'h008);
        drain(1'b1, "R6 sw single");
        // R6 software bit ignored in hardware mode
        xbar_sw_mode = 8'h00;
        pulse(8'h00, 2'b00, 8'h10);
        drain(1'b0, "R6 sw ignored in hw");

        // R7 touch sources
        p[8] = 7; p[9] = 7; p[0] = 7;
        set_prio();
        touch_bypass = 1'b0;
        touch_en = 2'b01;
        pulse(8'h00, 2'b11, 8'h00);
        expect_set(10'h100);
        drain(1'b1, "R7 touch enable");
        touch_en = 2'b11;
        pulse(8'h01, 2'b11, 8'h00);
        expect_set(10'h301);
        drain(1'b0, "R7 touch tie");
        touch_bypass = 1'b1;
        pulse(8'h00, 2'b11, 8'h00);
        drain(1'b0, "R7 bypass");

        // R8 soft reset clears pending
        pulse(8'hFF, 2'b00, 8'h00);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        drain(1'b0, "R8 soft reset");

        // R5 pending held across a long wait
        xbar_en = 8'h40;
        pulse(8'h40, 2'b00, 8'h00);
        repeat (50) @(negedge clk);
        chk(grant_valid == 1'b0, "R5 held without ready", int'(grant_valid), 0);
        expect_set(10'h040);
        drain(1'b1, "R5 late grant");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        chk(1'b0, "watchdog", cycles, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule